// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps a 512-row DRAM alive and brings it out of power-on. After reset it stays quiet for a settling pause. It then runs a fixed number of wake-up cycles on the strobe lines, with no arbitration, and only after that raises `ready_o`. In normal operation an interval timer adds one owed refresh every `REFRESH_INTERVAL` clocks. At the default 50 MHz that is 781 clocks, so 512 refreshes fit in 8 ms. While any refresh is owed, the block asks the access controller for the shared strobe lines.

The controller answers each request with a one-cycle grant. The block then drives one refresh cycle in which CAS falls before RAS. Both byte CAS lines fall together, and write enable and output enable stay high. The DRAM takes the row from its own counter, so the block drives no address and the data bus stays released. The debt counter lets the controller put off a few refreshes while it keeps a page open. Once the debt reaches `FORCE_THRESH`, the block raises an urgent flag that the controller must honour.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst_ni` is low, `ras_n_o`, `lcas_n_o`, `ucas_n_o`, `we_n_o` and `oe_n_o` are 1, and `ready_o`, `req_o`, `force_o` and `busy_o` are 0. This holds again after a reset applied in normal operation.
- R2: After reset is released, all strobes stay high for at least `PWR_WAIT` clock cycles.
- R3: After the pause, exactly `INIT_CYCLES` refresh cycles run without any grant, and then `ready_o` goes to 1 and stays there. `req_o` is never 1 while `ready_o` is 0.
- R4: Every refresh is CAS-before-RAS. CAS (value 0) is low for at least `T_CSR` cycles before RAS falls, and CAS stays low for every cycle in which RAS is low.
- R5: `lcas_n_o` always equals `ucas_n_o`. `we_n_o` and `oe_n_o` are 1 in every cycle.
- R6: RAS stays low for exactly `T_RAS` cycles. After RAS rises, it stays high for at least `T_RP + T_CSR` cycles before it falls again.
- R7: Once ready, one refresh is added to the debt every `REFRESH_INTERVAL` cycles. `req_o` is 1 whenever the debt is non-zero and no cycle is in progress.
- R8: A cycle with `grant_i`=1 and `req_o`=1 starts one refresh: on the next cycle `busy_o` is 1 and CAS is low. Each completed refresh lowers the debt by one. `grant_i` has no effect while `req_o` is 0.
- R9: The debt saturates at `PEND_MAX`. `force_o` is 1 exactly while the debt is `FORCE_THRESH` or more.
- R10: `busy_o` is 1 from the cycle after a start until precharge ends. While `busy_o` is 0 the strobes are high, and while `busy_o` is 1 `req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grant_i | input | 1 | One-cycle grant of the strobe lines from the access controller |
| req_o | output | 1 | Refresh owed and strobe lines wanted |
| force_o | output | 1 | Debt at or above the urgent threshold |
| busy_o | output | 1 | Block owns the strobe lines for a refresh cycle |
| ready_o | output | 1 | Power-up sequence finished |
| ras_n_o | output | 1 | Row strobe, active low |
| lcas_n_o | output | 1 | Lower byte column strobe, active low |
| ucas_n_o | output | 1 | Upper byte column strobe, active low |
| we_n_o | output | 1 | Write enable, held inactive |
| oe_n_o | output | 1 | Output enable, held inactive |

## Verification
The assertions check local properties on every cycle:
- CAS-before-RAS order and CAS held while RAS is low
- the two CAS lines moving together
- strobes idle whenever the block is not busy
- no request before ready, and ready sticking once set
- a grant always starting a cycle on the next edge

The bench scenarios cover the properties that need counting over long windows:
- the length of the power-up pause and the exact number of wake-up cycles
- the RAS low width and the gap between refreshes
- debt built up over several timer intervals, saturation of the debt at its limit, and the urgent threshold
- grants offered with no debt having no effect

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;
  typedef enum logic [1:0] {
    MODE_WAIT = 2'd0,
    MODE_INIT = 2'd1,
    MODE_RUN  = 2'd2
  } seq_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SETUP = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_PRECH = 2'd3
  } strobe_phase_e;
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int unsigned INTERVAL = 781
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [W-1:0] LAST = W'(INTERVAL - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!en_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/refresh_debt_counter.sv
module refresh_debt_counter #(
  parameter int unsigned PEND_MAX     = 8,
  parameter int unsigned FORCE_THRESH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic owed_o,
  output logic force_o
);
  localparam int unsigned W = $clog2(PEND_MAX + 1);
  localparam logic [W-1:0] MAXV = W'(PEND_MAX);
  localparam logic [W-1:0] THR  = W'(FORCE_THRESH);

  logic [W-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
    end else if (inc_i && !dec_i) begin
      if (lvl_q != MAXV) lvl_q <= lvl_q + 1'b1;  // saturate, never wrap
    end else if (dec_i && !inc_i) begin
      if (lvl_q != '0) lvl_q <= lvl_q - 1'b1;
    end
  end

  assign owed_o  = (lvl_q != '0);
  assign force_o = (lvl_q >= THR);
endmodule

// File: rtl/cbr_strobe_fsm.sv
module cbr_strobe_fsm
  import dram_refresh_pkg::*;
#(
  parameter int unsigned T_CSR = 1,
  parameter int unsigned T_RAS = 4,
  parameter int unsigned T_RP  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned MAXT = (T_CSR > T_RAS) ? ((T_CSR > T_RP) ? T_CSR : T_RP)
                                                 : ((T_RAS > T_RP) ? T_RAS : T_RP);
  localparam int unsigned W = $clog2(MAXT + 1);
  localparam logic [W-1:0] CSR_LAST = W'(T_CSR - 1);
  localparam logic [W-1:0] RAS_LAST = W'(T_RAS - 1);
  localparam logic [W-1:0] RP_LAST  = W'(T_RP - 1);

  strobe_phase_e ph_q;
  logic [W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q  <= PH_SETUP;
          cnt_q <= '0;
        end
        PH_SETUP: if (cnt_q == CSR_LAST) begin
          ph_q  <= PH_ACTIVE;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        PH_ACTIVE: if (cnt_q == RAS_LAST) begin
          ph_q  <= PH_PRECH;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        PH_PRECH: if (cnt_q == RP_LAST) begin
          ph_q  <= PH_IDLE;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        default: begin
          ph_q  <= PH_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign busy_o  = (ph_q != PH_IDLE);
  assign ras_n_o = (ph_q != PH_ACTIVE);
  assign cas_n_o = !((ph_q == PH_SETUP) || (ph_q == PH_ACTIVE));
  assign done_o  = (ph_q == PH_PRECH) && (cnt_q == RP_LAST);
endmodule

// File: rtl/powerup_init_ctrl.sv
module powerup_init_ctrl
  import dram_refresh_pkg::*;
#(
  parameter int unsigned PWR_WAIT    = 10000,
  parameter int unsigned INIT_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic done_i,
  output logic start_o,
  output logic ready_o
);
  localparam int unsigned PW_W = $clog2(PWR_WAIT + 1);
  localparam int unsigned IN_W = $clog2(INIT_CYCLES + 1);
  localparam logic [PW_W-1:0] PW_LAST = PW_W'(PWR_WAIT - 1);
  localparam logic [IN_W-1:0] IN_LAST = IN_W'(INIT_CYCLES - 1);

  seq_mode_e       mode_q;
  logic [PW_W-1:0] wait_q;
  logic [IN_W-1:0] done_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_WAIT;
      wait_q     <= '0;
      done_cnt_q <= '0;
    end else begin
      unique case (mode_q)
        MODE_WAIT: begin
          if (wait_q == PW_LAST) mode_q <= MODE_INIT;
          else                   wait_q <= wait_q + 1'b1;
        end
        MODE_INIT: if (done_i) begin
          if (done_cnt_q == IN_LAST) mode_q <= MODE_RUN;
          else                       done_cnt_q <= done_cnt_q + 1'b1;
        end
        MODE_RUN: mode_q <= MODE_RUN;
        default:  mode_q <= MODE_WAIT;
      endcase
    end
  end

  // wake-up cycles need no grant: nothing else owns the strobes before ready
  assign start_o = (mode_q == MODE_INIT) && !busy_i;
  assign ready_o = (mode_q == MODE_RUN);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int unsigned REFRESH_INTERVAL = 781,
  parameter int unsigned PEND_MAX         = 8,
  parameter int unsigned FORCE_THRESH     = 4,
  parameter int unsigned PWR_WAIT         = 10000,
  parameter int unsigned INIT_CYCLES      = 8,
  parameter int unsigned T_CSR            = 1,
  parameter int unsigned T_RAS            = 4,
  parameter int unsigned T_RP             = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  output logic req_o,
  output logic force_o,
  output logic busy_o,
  output logic ready_o,
  output logic ras_n_o,
  output logic lcas_n_o,
  output logic ucas_n_o,
  output logic we_n_o,
  output logic oe_n_o
);
  logic tick, owed, busy, done, init_start, start, cas_n, ready;

  powerup_init_ctrl #(
    .PWR_WAIT   (PWR_WAIT),
    .INIT_CYCLES(INIT_CYCLES)
  ) u_init (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (busy),
    .done_i (done),
    .start_o(init_start),
    .ready_o(ready)
  );

  refresh_interval_timer #(
    .INTERVAL(REFRESH_INTERVAL)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ready),
    .tick_o(tick)
  );

  refresh_debt_counter #(
    .PEND_MAX    (PEND_MAX),
    .FORCE_THRESH(FORCE_THRESH)
  ) u_debt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (tick),
    .dec_i  (done && ready),
    .owed_o (owed),
    .force_o(force_o)
  );

  assign req_o = ready && owed && !busy;
  assign start = init_start || (req_o && grant_i);

  cbr_strobe_fsm #(
    .T_CSR(T_CSR),
    .T_RAS(T_RAS),
    .T_RP (T_RP)
  ) u_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .ras_n_o(ras_n_o),
    .cas_n_o(cas_n),
    .busy_o (busy),
    .done_o (done)
  );

  assign lcas_n_o = cas_n;
  assign ucas_n_o = cas_n;
  assign we_n_o   = 1'b1;  // refresh never transfers data
  assign oe_n_o   = 1'b1;
  assign busy_o   = busy;
  assign ready_o  = ready;
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic grant_i,
  input logic req_o,
  input logic force_o,
  input logic busy_o,
  input logic ready_o,
  input logic ras_n_o,
  input logic lcas_n_o,
  input logic ucas_n_o
);
  AST_CBR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> !$past(lcas_n_o)); // R4
  AST_CAS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> !lcas_n_o); // R4
  AST_CAS_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcas_n_o == ucas_n_o); // R5
  AST_PRECHARGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |=> ras_n_o); // R6
  AST_NO_EARLY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !req_o); // R3
  AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o); // R3
  AST_GRANT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && grant_i) |=> (busy_o && !lcas_n_o)); // R8
  AST_FORCE_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_o |-> (req_o || busy_o)); // R9
  AST_IDLE_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ras_n_o && lcas_n_o)); // R10
  AST_BUSY_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_o); // R10
endmodule

bind dram_refresh_seq dram_refresh_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .grant_i (grant_i),
  .req_o   (req_o),
  .force_o (force_o),
  .busy_o  (busy_o),
  .ready_o (ready_o),
  .ras_n_o (ras_n_o),
  .lcas_n_o(lcas_n_o),
  .ucas_n_o(ucas_n_o)
);

// File: tb/dram_refresh_seq_tb.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb;
  localparam int INTERVAL = 120;
  localparam int PMAX     = 6;
  localparam int FTHR     = 3;
  localparam int PWAIT    = 20;
  localparam int NINIT    = 8;
  localparam int TCSR     = 1;
  localparam int TRAS     = 3;
  localparam int TRP      = 2;

  // vector table: intervals of debt left ungranted, expected force, expected refreshes on drain
  localparam int NVEC = 5;
  localparam int VEC_DEFER [NVEC] = '{1, 2, 3, 4, 8};
  localparam int VEC_FORCE [NVEC] = '{0, 0, 1, 1, 1};
  localparam int VEC_DRAIN [NVEC] = '{1, 2, 3, 4, 6};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic grant_i = 1'b0;
  logic req_o, force_o, busy_o, ready_o, ras_n_o, lcas_n_o, ucas_n_o, we_n_o, oe_n_o;

  always #10 clk = ~clk;

  dram_refresh_seq #(
    .REFRESH_INTERVAL(INTERVAL), .PEND_MAX(PMAX), .FORCE_THRESH(FTHR),
    .PWR_WAIT(PWAIT), .INIT_CYCLES(NINIT), .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .grant_i(grant_i), .req_o(req_o), .force_o(force_o),
    .busy_o(busy_o), .ready_o(ready_o), .ras_n_o(ras_n_o), .lcas_n_o(lcas_n_o),
    .ucas_n_o(ucas_n_o), .we_n_o(we_n_o), .oe_n_o(oe_n_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle monitors
  int ras_falls = 0, cbr_bad = 0, width_bad = 0, gap_bad = 0, pair_bad = 0;
  int data_bad = 0, idle_bad = 0, early_req = 0;
  int low_len = 0, high_len = 0;
  bit seen_rise = 1'b0, prev_ras = 1'b1, prev_cas = 1'b1;

  always @(negedge clk) begin
    if (!rst_ni) begin
      prev_ras = 1'b1; prev_cas = 1'b1; low_len = 0; high_len = 0; seen_rise = 1'b0;
    end else begin
      if (prev_ras && !ras_n_o) begin
        ras_falls++;
        if (prev_cas || lcas_n_o) cbr_bad++;
        if (seen_rise && high_len < TRP + TCSR) gap_bad++;
        high_len = 0;
      end
      if (!prev_ras && ras_n_o) begin
        if (low_len != TRAS) width_bad++;
        low_len = 0;
        seen_rise = 1'b1;
      end
      if (!ras_n_o) begin
        low_len++;
        if (lcas_n_o) cbr_bad++;
      end else high_len++;
      if (lcas_n_o != ucas_n_o) pair_bad++;
      if (!we_n_o || !oe_n_o) data_bad++;
      if (!busy_o && (!ras_n_o || !lcas_n_o)) idle_bad++;
      if (!ready_o && req_o) early_req++;
      prev_ras = ras_n_o;
      prev_cas = lcas_n_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    int f0;
    // R1 reset state
    repeat (4) @(negedge clk);
    check(ras_n_o && lcas_n_o && ucas_n_o, "R1 strobes high in reset", {ras_n_o, lcas_n_o}, 3);
    check(we_n_o && oe_n_o, "R1 we/oe high in reset", {we_n_o, oe_n_o}, 3);
    check(!ready_o, "R1 ready low", ready_o, 0);
    check(!req_o, "R1 req low", req_o, 0);
    check(!force_o, "R1 force low", force_o, 0);
    check(!busy_o, "R1 busy low", busy_o, 0);

    // R2 power-up pause
    rst_ni = 1'b1;
    cyc = 0;
    while (lcas_n_o && ras_n_o && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc >= PWAIT + 1 && cyc < 1000, "R2 quiet cycles before first strobe", cyc, PWAIT + 1);

    // R3 wake-up cycles then ready
    cyc = 0;
    while (!ready_o && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    @(posedge clk);
    check(ready_o == 1'b1, "R3 ready rises", ready_o, 1);
    check(ras_falls == NINIT, "R3 wake-up cycle count", ras_falls, NINIT);
    check(early_req == 0, "R3 no req before ready", early_req, 0);

    // R8 grant with no debt is ignored
    @(negedge clk);
    f0 = ras_falls;
    grant_i = 1'b1;
    repeat (60) @(negedge clk);
    grant_i = 1'b0;
    @(posedge clk);
    check(ras_falls == f0, "R8 grant ignored without req", ras_falls - f0, 0);

    // R7/R8/R9 vector walk
    for (int v = 0; v < NVEC; v++) begin
      cyc = 0;
      while (!req_o && cyc < 400) begin
        @(negedge clk);
        cyc++;
      end
      check(cyc > 0 && cyc < 400, "R7 tick raises req", cyc, 1);
      repeat ((VEC_DEFER[v] - 1) * INTERVAL + 40) @(negedge clk);
      check(force_o == VEC_FORCE[v][0], "R9 force level", force_o, VEC_FORCE[v]);
      f0 = ras_falls;
      repeat (70) begin
        @(negedge clk);
        grant_i = req_o;
      end
      grant_i = 1'b0;
      @(posedge clk);
      check(ras_falls - f0 == VEC_DRAIN[v], "R8 R9 refreshes per drain", ras_falls - f0, VEC_DRAIN[v]);
      @(negedge clk);
      check(!req_o && !force_o, "R8 debt drained", {req_o, force_o}, 0);
    end

    // monitor results
    @(posedge clk);
    check(cbr_bad == 0, "R4 CAS before and during RAS", cbr_bad, 0);
    check(pair_bad == 0, "R5 byte CAS paired", pair_bad, 0);
    check(data_bad == 0, "R5 we/oe inactive", data_bad, 0);
    check(width_bad == 0, "R6 RAS low width", width_bad, 0);
    check(gap_bad == 0, "R6 precharge gap", gap_bad, 0);
    check(idle_bad == 0, "R10 strobes idle when not busy", idle_bad, 0);

    // R1 reset during normal operation
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(!ready_o && !req_o && !busy_o, "R1 reset clears state", {ready_o, req_o, busy_o}, 0);
    check(ras_n_o && lcas_n_o, "R1 reset frees strobes", {ras_n_o, lcas_n_o}, 3);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule